// File: doc/BRIEF.md
# Dual-Base Translation Table Address Selector

This block produces the address of the first-level translation descriptor when a table walk begins after a TLB miss. A walk request brings a 32-bit virtual address and the security state of the requester. The block compares the top bits of the address against a programmable split value N. From that comparison it picks one of two table base registers and forms the word-aligned address of the descriptor to fetch.

The lower region of the virtual space, from zero up to 1<<(32-N), is served by base 0. Its table shrinks as N grows: it holds 4096>>N four-byte entries and always starts with the entry for address zero. The upper region is served by base 1 through a full 16 KB table. With N equal to zero, base 0 covers every address. The split value and both base registers exist in two copies, one Secure and one Non-secure. A simple write port loads them, and the security state of each request picks the copy it uses. The result appears one cycle after the request, marked by a one-cycle valid pulse.

Top module: `ttw_base_select`

## Requirements
- R1: After reset, every banked register (split value, base 0, base 1, in both security copies) reads as zero and `desc_valid` is low.
- R2: A `walk_req` high in the cycle before clock edge t makes `desc_valid` high for exactly the cycle after edge t. `desc_valid` is low after any edge where `walk_req` was low, and `desc_addr` and `desc_base_sel` then hold their previous values.
- R3: When the split value selected for the request is 0, `desc_base_sel` is 0 (base 0) for every virtual address, including 0xFFFFFFFF.
- R4: When the split value N is 1 to 7, an address below 1<<(32-N) gives `desc_base_sel` = 0. An address at or above that boundary gives `desc_base_sel` = 1.
- R5: For base 0, `desc_addr` equals base0 with its low 14-N bits cleared, plus 4 times (va>>20). This is a table of 4096>>N entries whose first entry maps address zero.
- R6: For base 1, `desc_addr` equals base1 with its low 14 bits cleared, plus 4 times (va>>20). In both cases bits [1:0] of `desc_addr` are zero.
- R7: `walk_ns` = 0 uses the Secure copy and `walk_ns` = 1 uses the Non-secure copy. A write with `cfg_ns` = 0 changes only the Secure copy, and a write with `cfg_ns` = 1 changes only the Non-secure copy.
- R8: A write with `cfg_we` = 1 decodes `cfg_sel` as follows: 0 loads the split value from `cfg_wdata[2:0]`, 1 loads base 0, and 2 loads base 1, each from `cfg_wdata`. A value of 3 changes no register.
- R9: A register write in the same cycle as a walk request affects only later requests. The request in that cycle uses the values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Table walk start strobe |
| walk_va | input | 32 | Virtual address that missed |
| walk_ns | input | 1 | Security state of the request (1 = Non-secure) |
| cfg_we | input | 1 | Register write strobe |
| cfg_ns | input | 1 | Register copy to write (1 = Non-secure) |
| cfg_sel | input | 2 | Register to write: 0 split, 1 base 0, 2 base 1, 3 none |
| cfg_wdata | input | 32 | Write data |
| desc_valid | output | 1 | One-cycle pulse: descriptor address ready |
| desc_base_sel | output | 1 | Base used: 0 or 1 |
| desc_addr | output | 32 | First-level descriptor address |

## Verification
Some properties are checked on every cycle. These are the one-cycle valid pulse and the holding of outputs between requests. The assertions also check that a split value of zero never selects base 1, that the result keeps the upper bits of the chosen base, and that the address is word-aligned. Other behaviour can only be shown by the directed scenarios. These cover where the boundary falls for each N on both sides, the shrinking index field of the lower table, and whether writes to one security copy leave the other untouched. They also cover the reserved write select and the rule that a write landing with a request affects only the requests after it.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int VA_W      = 32;
  localparam int SPLIT_W   = 3;
  localparam int FULL_SH   = 14;  // log2 of full table bytes
  localparam int SECT_SH   = 20;  // log2 of bytes mapped per entry
  localparam int IDX_W     = VA_W - SECT_SH;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    CFG_SPLIT = 2'd0,
    CFG_BASE0 = 2'd1,
    CFG_BASE1 = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [SPLIT_W-1:0] split;
    logic [VA_W-1:0]    base0;
    logic [VA_W-1:0]    base1;
  } ttw_bank_t;

  // Any of the top n address bits set -> upper region.
  function automatic logic in_upper(input logic [VA_W-1:0] va,
                                    input logic [SPLIT_W-1:0] n);
    logic [VA_W-1:0] top_mask;
    top_mask = ~({VA_W{1'b1}} >> n);
    return |(va & top_mask);
  endfunction

  // Truncated lower table: base bits above 14-n, index of 12-n bits.
  function automatic logic [VA_W-1:0] lower_addr(input logic [VA_W-1:0] base,
                                                 input logic [VA_W-1:0] va,
                                                 input logic [SPLIT_W-1:0] n);
    logic [VA_W-1:0] keep;
    logic [VA_W-1:0] idx;
    keep = {VA_W{1'b1}} << (FULL_SH - int'(n));
    idx  = (va >> SECT_SH) & ({{SECT_SH{1'b0}}, {IDX_W{1'b1}}} >> n);
    return (base & keep) | (idx << 2);
  endfunction

  // Full-size upper table.
  function automatic logic [VA_W-1:0] upper_addr(input logic [VA_W-1:0] base,
                                                 input logic [VA_W-1:0] va);
    return {base[VA_W-1:FULL_SH], va[VA_W-1:SECT_SH], 2'b00};
  endfunction
endpackage

// File: rtl/ttw_bank_regs.sv
module ttw_bank_regs
  import ttw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_ns,
  input  logic [1:0]      wr_sel,
  input  logic [VA_W-1:0] wr_data,
  input  logic            rd_ns,
  output ttw_bank_t       rd_bank
);
  ttw_bank_t bank_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (wr_ns == 1'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[b] <= '0;
      end else if (hit) begin
        case (cfg_sel_e'(wr_sel))
          CFG_SPLIT: bank_q[b].split <= wr_data[SPLIT_W-1:0];
          CFG_BASE0: bank_q[b].base0 <= wr_data;
          CFG_BASE1: bank_q[b].base1 <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  assign rd_bank = bank_q[rd_ns];
endmodule

// File: rtl/ttw_addr_gen.sv
module ttw_addr_gen
  import ttw_pkg::*;
(
  input  ttw_bank_t       bank,
  input  logic [VA_W-1:0] va,
  output logic            use_upper,
  output logic [VA_W-1:0] addr
);
  logic [VA_W-1:0] lo_addr;
  logic [VA_W-1:0] hi_addr;

  always_comb begin
    use_upper = in_upper(va, bank.split);
    lo_addr   = lower_addr(bank.base0, va, bank.split);
    hi_addr   = upper_addr(bank.base1, va);
    addr      = use_upper ? hi_addr : lo_addr;
  end
endmodule

// File: rtl/ttw_base_select.sv
module ttw_base_select
  import ttw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_req,
  input  logic [31:0] walk_va,
  input  logic        walk_ns,
  input  logic        cfg_we,
  input  logic        cfg_ns,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        desc_valid,
  output logic        desc_base_sel,
  output logic [31:0] desc_addr
);
  ttw_bank_t       cur_bank;
  logic            sel_upper;
  logic [VA_W-1:0] next_addr;

  ttw_bank_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_ns   (cfg_ns),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .rd_ns   (walk_ns),
    .rd_bank (cur_bank)
  );

  ttw_addr_gen u_gen (
    .bank      (cur_bank),
    .va        (walk_va),
    .use_upper (sel_upper),
    .addr      (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid    <= 1'b0;
      desc_base_sel <= 1'b0;
      desc_addr     <= '0;
    end else begin
      desc_valid <= walk_req;
      if (walk_req) begin
        desc_base_sel <= sel_upper;
        desc_addr     <= next_addr;
      end
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> desc_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_req |=> !desc_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_req |=> $stable(desc_addr) && $stable(desc_base_sel)); // R2
  AST_SPLIT0_BASE0: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && cur_bank.split == '0 |=> !desc_base_sel); // R3
  AST_UPPER_BASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && sel_upper |=>
      desc_addr[VA_W-1:FULL_SH] == $past(cur_bank.base1[VA_W-1:FULL_SH])); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_addr[1:0] == 2'b00); // R6
endmodule

// File: tb/sim_ttw_base_select.sv
module sim_ttw_base_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [31:0] walk_va = '0;
  logic        walk_ns = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_ns = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        desc_valid;
  logic        desc_base_sel;
  logic [31:0] desc_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side register copies, index 0 Secure, 1 Non-secure.
  int unsigned m_split [2];
  logic [31:0] m_b0 [2];
  logic [31:0] m_b1 [2];

  always #5 clk = ~clk;

  ttw_base_select u0 (.*);

  function automatic bit exp_upper(input logic [31:0] va, input int unsigned n);
    longint unsigned bound;
    bound = 64'h1_0000_0000 >> n;
    return (n != 0) && (longint'(va) >= bound);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] va, input int s);
    longint unsigned gran;
    longint unsigned base;
    if (exp_upper(va, m_split[s])) begin
      gran = 16384;
      base = m_b1[s];
    end else begin
      gran = 16384 >> m_split[s];
      base = m_b0[s];
    end
    return 32'((base / gran) * gran + (longint'(va) >> 20) * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit ns, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ns = ns; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_split[ns] = d[2:0];
      2'd1: m_b0[ns] = d;
      2'd2: m_b1[ns] = d;
      default: ;
    endcase
  endtask

  // Issue one walk and check the result one cycle later.
  task automatic walk(input string req, input logic [31:0] va, input bit ns);
    logic [31:0] ea;
    bit eu;
    ea = exp_addr(va, ns);
    eu = exp_upper(va, m_split[ns]);
    @(negedge clk);
    walk_req = 1'b1; walk_va = va; walk_ns = ns;
    @(negedge clk);
    walk_req = 1'b0;
    check(req, 32'(desc_valid), 32'd1);
    check(req, 32'(desc_base_sel), 32'(eu));
    check(req, desc_addr, ea);
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(desc_valid), 32'd0);
    check("R1 addr", desc_addr, 32'd0);
    walk("R1 walk zero regs", 32'hFFFF_FFFF, 1'b0);
    walk("R1 walk zero regs ns", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_pulse_hold;
    logic [31:0] a;
    wr(1'b0, 2'd1, 32'h1234_5678);
    walk("R2 walk", 32'h0030_0000, 1'b0);
    a = desc_addr;
    walk_va = 32'hFFF0_0000;
    @(negedge clk);
    check("R2 pulse ends", 32'(desc_valid), 32'd0);
    check("R2 addr held", desc_addr, a);
    @(negedge clk);
    check("R2 addr still held", desc_addr, a);
  endtask

  task automatic t_split0;
    walk("R3 N=0 top", 32'hFFFF_FFFF, 1'b0);
    walk("R3 N=0 mid", 32'h8000_0000, 1'b0);
    walk("R5 N=0 low", 32'h0010_0000, 1'b0);
  endtask

  task automatic t_sweep;
    wr(1'b0, 2'd1, 32'hA5A5_A5A5);
    wr(1'b0, 2'd2, 32'h5A5A_5A5A);
    for (int n = 1; n < 8; n++) begin
      logic [31:0] bnd;
      wr(1'b0, 2'd0, 32'hFFFF_FFF8 | 32'(n));
      bnd = 32'(64'h1_0000_0000 >> n);
      walk("R4 R5 below boundary", bnd - 32'd1, 1'b0);
      walk("R4 R6 at boundary", bnd, 1'b0);
      walk("R5 address zero", 32'h0000_0000, 1'b0);
      walk("R6 top", 32'hFFFF_FFFF, 1'b0);
    end
  endtask

  task automatic t_bank;
    wr(1'b1, 2'd0, 32'd2);
    wr(1'b1, 2'd1, 32'h0BAD_0000);
    wr(1'b1, 2'd2, 32'hC0DE_C000);
    walk("R7 ns lower", 32'h3FF0_0000, 1'b1);
    walk("R7 ns upper", 32'h4000_0000, 1'b1);
    walk("R7 secure untouched", 32'h4000_0000, 1'b0);
    wr(1'b0, 2'd0, 32'd0);
    walk("R7 secure N=0", 32'hC000_0000, 1'b0);
    walk("R7 ns keeps N=2", 32'hC000_0000, 1'b1);
  endtask

  task automatic t_reserved;
    wr(1'b1, 2'd3, 32'hFFFF_FFFF);
    walk("R8 sel3 no effect lower", 32'h1230_0000, 1'b1);
    walk("R8 sel3 no effect upper", 32'hF000_0000, 1'b1);
    wr(1'b1, 2'd0, 32'hFFFF_FFF9);
    walk("R8 split from wdata[2:0]", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] ea;
    ea = exp_addr(32'h0050_0000, 0);
    @(negedge clk);
    walk_req = 1'b1; walk_va = 32'h0050_0000; walk_ns = 1'b0;
    cfg_we = 1'b1; cfg_ns = 1'b0; cfg_sel = 2'd1; cfg_wdata = 32'h7777_0000;
    @(negedge clk);
    walk_req = 1'b0; cfg_we = 1'b0;
    m_b0[0] = 32'h7777_0000;
    check("R9 old base used", desc_addr, ea);
    walk("R9 new base later", 32'h0050_0000, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_split[i] = 0; m_b0[i] = '0; m_b1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse_hold();
    t_split0();
    t_sweep();
    t_bank();
    t_reserved();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule